// File: doc/BRIEF.md
# Dual-Mode Parallel Display Bus Master

This block is the host side of an asynchronous parallel bus to a display controller. A system-side requester hands it one transfer at a time: a write to the index register, a write of a parameter or pixel word, or a read of status or frame data. The block then runs the whole bus cycle itself. It asserts chip select, drives register select and, for writes, the data. It pulses the strobe and keeps everything stable through a hold window. After a recovery gap it returns an acknowledge, together with the read word when the transfer was a read.

A mode input picks between two strobe styles. In the first, separate active-low write and read strobes are used. In the second, a read/write select line and an active-high enable are used. Every phase length is a clock-count parameter, and the read phases are separate and slower than the write phases. A width code selects among full 18-bit, 16-bit, 9-bit and 8-bit transfers. The narrow widths map onto fixed, partly non-contiguous data pins.

Top module: `disp_bus_master`

## Requirements
- R1: After reset, chip select (`csb_o`) is high, `busy` and `ack` are low, both strobe lines are high, and `db_oe_o` is low.
- R2: With `mode_68`=0, a write pulls `wr_o` low for exactly `WR_LO_CYC` cycles while `rd_o` stays high. `db_o` holds the mapped write word, stable, from chip-select fall until chip-select rise.
- R3: With `mode_68`=0, a read pulls `rd_o` low for exactly `RD_LO_CYC` cycles while `wr_o` stays high and `db_oe_o` stays low.
- R4: With `mode_68`=1, `wr_o` acts as read/write select (0 = write, 1 = read) and holds that value for the whole chip-select window. `rd_o` acts as an active-high enable, high for `WR_LO_CYC` cycles on writes or `RD_LO_CYC` cycles on reads.
- R5: `rs_o` equals the request's `req_rs` and stays stable while chip select is low (0 = index/status, 1 = parameter/data).
- R6: Chip select falls exactly `SETUP_CYC` cycles before the strobe becomes active and rises exactly `HOLD_CYC` cycles after it ends. A strobe is never active with chip select high.
- R7: After chip select rises, the block stays busy for `WR_HI_CYC` cycles on a write, or `RD_HI_CYC` cycles on a read, before it can accept the next request.
- R8: `ack` is a single-cycle pulse at the end of each transfer. On a read, `rd_data` then holds the bus value sampled on the last clock with the strobe active, unmapped per width.
- R9: Width code 0 maps data[17:0] to pins 17..0. Code 1 maps data[15:8] to pins 17..10 and data[7:0] to pins 8..1. Code 2 maps data[8:0] to pins 8..0. Code 3 maps data[7:0] to pins 8..1. Pins not used by the width are driven low on writes. On reads the unused upper bits of `rd_data` are zero.
- R10: `busy` is high from the cycle after a request is accepted until `ack`. A `req_valid` seen while busy is ignored and starts no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_68 | input | 1 | 0 = separate write/read strobes, 1 = read/write select plus enable |
| bus_width | input | 2 | Width code: 0 = 18, 1 = 16, 2 = 9, 3 = 8 bits |
| req_valid | input | 1 | Transfer request, taken when not busy |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_rs | input | 1 | Register select for the transfer |
| req_wdata | input | 18 | Write word (right-aligned) |
| busy | output | 1 | Transfer in progress |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 18 | Read word (right-aligned) |
| csb_o | output | 1 | Chip select, active low |
| rs_o | output | 1 | Register select to the bus |
| wr_o | output | 1 | Write strobe (mode 0) or read/write select (mode 1) |
| rd_o | output | 1 | Read strobe (mode 0) or enable (mode 1) |
| db_o | output | 18 | Data pins, driven value |
| db_oe_o | output | 1 | Data pin drive enable |
| db_i | input | 18 | Data pins, sampled value |

## Verification
The hardest situation to reach is a read whose bus value changes while the strobe is still active. The capture must take the value from the final active cycle, not an earlier one. The bench changes `db_i` a few cycles into every read strobe and expects only the later value back. It also raises a second request in the middle of every strobe, to show that a request during busy starts nothing. Random mixes of mode, width, direction and register select then cover every pin mapping in both strobe styles.

// File: rtl/disp_bus_master.sv
module disp_bus_master #(
  parameter int SETUP_CYC = 4,
  parameter int WR_LO_CYC = 7,
  parameter int WR_HI_CYC = 10,
  parameter int RD_LO_CYC = 63,
  parameter int RD_HI_CYC = 63,
  parameter int HOLD_CYC  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_68,
  input  logic [1:0]  bus_width,
  input  logic        req_valid,
  input  logic        req_rd,
  input  logic        req_rs,
  input  logic [17:0] req_wdata,
  output logic        busy,
  output logic        ack,
  output logic [17:0] rd_data,
  output logic        csb_o,
  output logic        rs_o,
  output logic        wr_o,
  output logic        rd_o,
  output logic [17:0] db_o,
  output logic        db_oe_o,
  input  logic [17:0] db_i
);
  localparam int M1   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int M2   = (WR_LO_CYC > WR_HI_CYC) ? WR_LO_CYC : WR_HI_CYC;
  localparam int M3   = (RD_LO_CYC > RD_HI_CYC) ? RD_LO_CYC : RD_HI_CYC;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M12 > M3) ? M12 : M3;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACT, S_HOLD, S_REC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          mode_q, rd_q;
  logic [1:0]    wid_q;

  function automatic logic [17:0] map_out(input logic [17:0] d, input logic [1:0] w);
    case (w)
      2'd0:    map_out = d;
      2'd1:    map_out = {d[15:8], 1'b0, d[7:0], 1'b0};
      2'd2:    map_out = {9'b0, d[8:0]};
      default: map_out = {9'b0, d[7:0], 1'b0};
    endcase
  endfunction

  function automatic logic [17:0] map_in(input logic [17:0] b, input logic [1:0] w);
    case (w)
      2'd0:    map_in = b;
      2'd1:    map_in = {2'b0, b[17:10], b[8:1]};
      2'd2:    map_in = {9'b0, b[8:0]};
      default: map_in = {10'b0, b[8:1]};
    endcase
  endfunction

  wire last = (cnt == '0);
  wire strobe_act = mode_q ? rd_o : (!wr_o || !rd_o);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      mode_q  <= 1'b0;
      rd_q    <= 1'b0;
      wid_q   <= 2'd0;
      ack     <= 1'b0;
      rd_data <= '0;
      csb_o   <= 1'b1;
      rs_o    <= 1'b1;
      wr_o    <= 1'b1;
      rd_o    <= 1'b1;
      db_o    <= '0;
      db_oe_o <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE: begin
          mode_q <= mode_68;
          rd_o   <= ~mode_68;
          wr_o   <= 1'b1;
          if (req_valid) begin
            st      <= S_SETUP;
            cnt     <= CW'(SETUP_CYC - 1);
            rd_q    <= req_rd;
            wid_q   <= bus_width;
            rs_o    <= req_rs;
            csb_o   <= 1'b0;
            wr_o    <= mode_68 ? req_rd : 1'b1;
            db_o    <= req_rd ? 18'd0 : map_out(req_wdata, bus_width);
            db_oe_o <= ~req_rd;
          end
        end
        S_SETUP: begin
          if (last) begin
            st  <= S_ACT;
            cnt <= rd_q ? CW'(RD_LO_CYC - 1) : CW'(WR_LO_CYC - 1);
            if (mode_q)    rd_o <= 1'b1;
            else if (rd_q) rd_o <= 1'b0;
            else           wr_o <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        S_ACT: begin
          if (last) begin
            st  <= S_HOLD;
            cnt <= CW'(HOLD_CYC - 1);
            if (mode_q) rd_o <= 1'b0;
            else begin
              rd_o <= 1'b1;
              wr_o <= 1'b1;
            end
            if (rd_q) rd_data <= map_in(db_i, wid_q);
          end else cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          if (last) begin
            st      <= S_REC;
            cnt     <= rd_q ? CW'(RD_HI_CYC - 1) : CW'(WR_HI_CYC - 1);
            csb_o   <= 1'b1;
            db_oe_o <= 1'b0;
            db_o    <= '0;
            wr_o    <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_REC: begin
          if (last) begin
            st  <= S_IDLE;
            ack <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: the two strobes of the separate-strobe style never overlap
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mode_q && !wr_o && !rd_o));

  // R2: driven data stays put while the drive is enabled
  p_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (db_oe_o && $past(db_oe_o)) |-> $stable(db_o));

  // R4: read/write select held across the chip-select window
  p_rw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !csb_o && $past(!csb_o)) |-> $stable(wr_o));

  // R5: register select does not move under chip select
  p_rs_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!csb_o && $past(!csb_o)) |-> $stable(rs_o));

  // R6: strobe only inside chip select, never on the falling cycle
  p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_act |-> !csb_o);
  p_cs_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csb_o) |-> !strobe_act);

  // R8: acknowledge is one cycle wide
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R9: 8-bit width leaves pins 17..9 and 0 low
  p_unused_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (db_oe_o && wid_q == 2'd3) |-> (db_o[17:9] == 9'd0 && db_o[0] == 1'b0));

  // R10: a new cycle only starts from an idle block
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csb_o) |-> !$past(busy));
endmodule

// File: tb/sim_disp_bus_master.sv
module sim_disp_bus_master;
  localparam int SU = 4, WL = 7, WH = 10, RL = 63, RH = 63, HD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_68 = 1'b0, req_valid = 1'b0, req_rd = 1'b0, req_rs = 1'b0;
  logic [1:0] bus_width = 2'd0;
  logic [17:0] req_wdata = '0, db_i = '0;
  logic busy, ack, csb_o, rs_o, wr_o, rd_o, db_oe_o;
  logic [17:0] rd_data, db_o;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  disp_bus_master #(.SETUP_CYC(SU), .WR_LO_CYC(WL), .WR_HI_CYC(WH),
    .RD_LO_CYC(RL), .RD_HI_CYC(RH), .HOLD_CYC(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_68(mode_68), .bus_width(bus_width),
    .req_valid(req_valid), .req_rd(req_rd), .req_rs(req_rs), .req_wdata(req_wdata),
    .busy(busy), .ack(ack), .rd_data(rd_data), .csb_o(csb_o), .rs_o(rs_o),
    .wr_o(wr_o), .rd_o(rd_o), .db_o(db_o), .db_oe_o(db_oe_o), .db_i(db_i));

  function automatic logic [17:0] exp_out(input logic [17:0] d, input logic [1:0] w);
    case (w)
      2'd0:    exp_out = d;
      2'd1:    exp_out = {d[15:8], 1'b0, d[7:0], 1'b0};
      2'd2:    exp_out = {9'b0, d[8:0]};
      default: exp_out = {9'b0, d[7:0], 1'b0};
    endcase
  endfunction

  function automatic logic [17:0] exp_in(input logic [17:0] b, input logic [1:0] w);
    case (w)
      2'd0:    exp_in = b;
      2'd1:    exp_in = {2'b0, b[17:10], b[8:1]};
      2'd2:    exp_in = {9'b0, b[8:0]};
      default: exp_in = {10'b0, b[8:1]};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit m, input logic [1:0] w, input bit rd, input bit rs,
                      input logic [17:0] d, input logic [17:0] v1, input logic [17:0] v2);
    int nsu = 0, nact = 0, nhd = 0, nrec = 0, guard = 0;
    bit bad_strobe = 0, bad_data = 0, bad_rs = 0, bad_rw = 0, bad_busy = 0;
    bit act;
    logic [17:0] xd = exp_out(d, w);
    @(negedge clk);
    mode_68 = m; bus_width = w; req_rd = rd; req_rs = rs; req_wdata = d;
    db_i = v1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!ack && guard < 1000) begin
      guard++;
      act = m ? rd_o : (!wr_o || !rd_o);
      if (!csb_o) begin
        if (rs_o !== rs) bad_rs = 1;
        if (m && wr_o !== rd) bad_rw = 1;
        if (!rd && (db_o !== xd || db_oe_o !== 1'b1)) bad_data = 1;
        if (rd && db_oe_o !== 1'b0) bad_data = 1;
      end
      if (!busy) bad_busy = 1;
      if (act) begin
        nact++;
        if (csb_o) bad_strobe = 1;
        if (!m && rd && !(rd_o == 1'b0 && wr_o == 1'b1)) bad_strobe = 1;
        if (!m && !rd && !(wr_o == 1'b0 && rd_o == 1'b1)) bad_strobe = 1;
        if (nact == 1) begin
          req_valid = 1'b1; req_rd = ~rd; req_wdata = ~d;
        end else req_valid = 1'b0;
        if (nact == 2) db_i = v2;
      end else if (!csb_o && nact == 0) nsu++;
      else if (!csb_o) nhd++;
      else nrec++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(ack === 1'b1 && busy === 1'b0, "R8 ack ends transfer", {ack, busy}, 2'b10);
    chk(nsu == SU, "R6 setup cycles", nsu, SU);
    chk(nhd == HD, "R6 hold cycles", nhd, HD);
    chk(nact == (rd ? RL : WL), rd ? (m ? "R4 enable width read" : "R3 read strobe width")
                                   : (m ? "R4 enable width write" : "R2 write strobe width"),
        nact, rd ? RL : WL);
    chk(nrec == (rd ? RH : WH), "R7 recovery cycles", nrec, rd ? RH : WH);
    chk(!bad_strobe, m ? "R4 strobe lines" : (rd ? "R3 strobe lines" : "R2 strobe lines"), bad_strobe, 0);
    chk(!bad_data, rd ? "R3 data drive off" : "R9 R2 write pin mapping", bad_data, 0);
    chk(!bad_rs, "R5 register select", bad_rs, 0);
    if (m) chk(!bad_rw, "R4 read/write select", bad_rw, 0);
    chk(!bad_busy, "R10 busy during transfer", bad_busy, 0);
    if (rd) chk(rd_data === exp_in(v2, w), "R8 R9 read capture", rd_data, exp_in(v2, w));
    @(negedge clk);
    chk(ack === 1'b0, "R8 ack single cycle", ack, 0);
    chk(csb_o === 1'b1 && busy === 1'b0, "R10 request during busy ignored", {csb_o, busy}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(csb_o === 1 && busy === 0 && ack === 0 && wr_o === 1 && rd_o === 1 && db_oe_o === 0,
        "R1 reset state", {csb_o, busy, ack, wr_o, rd_o, db_oe_o}, 6'b100110);
    rst_n = 1'b1;
    xfer(0, 2'd0, 0, 0, 18'h2A5C3, 0, 0);
    xfer(0, 2'd1, 0, 1, 18'h3FFFF, 0, 0);
    xfer(0, 2'd2, 0, 1, 18'h3FFFF, 0, 0);
    xfer(0, 2'd3, 0, 1, 18'h3FFFF, 0, 0);
    xfer(0, 2'd1, 1, 0, 0, 18'h00000, 18'h3FFFF);
    xfer(1, 2'd3, 1, 1, 0, 18'h3FFFF, 18'h155AA);
    xfer(1, 2'd0, 0, 1, 18'h1E0F1, 0, 0);
    xfer(1, 2'd2, 1, 0, 0, 18'h12345, 18'h2BCDE);
    for (int i = 0; i < 40; i++)
      xfer($urandom_range(1, 0), 2'($urandom_range(3, 0)), $urandom_range(1, 0),
           $urandom_range(1, 0), 18'($urandom), 18'($urandom), 18'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule